// File: doc/BRIEF.md
# UART Modem Handshake Monitor

This block is the handshake half of a UART. It drives two handshake outputs toward the modem (terminal-ready and request), watches four handshake inputs from it (send-ok, peer-ready, carrier and ring), and latches a delta flag for each input when that input moves. Three inputs flag any change. The ring input flags only its trailing edge, which is the fall from asserted to released. When any delta flag is set and the enable bit allows it, the block raises a modem-status interrupt request. All port levels are active high: 1 means asserted.

Software works the block through a small register port that has two locations. The control register at address 0 is read/write. The status register at address 1 is read-only. Reading the status register returns the current input levels and the delta flags, then clears the flags. For self-test, a loopback mode disconnects the external inputs, feeds the control bits back into the internal inputs and parks the external outputs.

A two-state mode machine selects the input source. In state MODE_NORMAL, the synchronized pins drive the internal inputs. In state MODE_LOOP, the control bits drive them. The transition NORMAL_TO_LOOP fires on a control write with the loop bit set. The transition LOOP_TO_NORMAL fires on a control write with the loop bit clear. Every other cycle holds the current state.

Top module: `modem_hs_ctrl`

## Requirements
- R1: After reset, both handshake outputs, the interrupt, every control bit and every delta flag are 0.
- R2: Control register (address 0): bit0 terminal-ready output, bit1 request output, bit2 loop ring source, bit3 loop carrier source, bit4 loop mode, bit5 interrupt enable. It reads back as written, upper bits 0. Outside loop mode, bit0 and bit1 appear on the outputs one cycle after the write.
- R3: Any level change on send-ok, peer-ready or carrier sets its delta flag. The flag becomes visible three clock edges after the pin changes: two synchronizer stages plus the flag register.
- R4: The ring delta flag is set only when ring goes from 1 to 0. A rise leaves it clear.
- R5: Status register (address 1): bits[3:0] are the delta flags for send-ok, peer-ready, carrier and ring, in that order. Bits[7:4] are the current internal levels in the same order. A read clears all delta flags at the following edge. A change detected at that same edge still leaves its flag set.
- R6: The interrupt output is 1 exactly when the enable bit is 1 and at least one delta flag is set.
- R7: In loop mode, the request bit drives internal send-ok, the terminal-ready bit drives peer-ready, control bit3 drives carrier and control bit2 drives ring. Deltas are detected on these values as on the pins.
- R8: In loop mode, the external inputs have no effect on levels, flags or interrupt, and both external outputs are held at 0.
- R9: On leaving loop mode, the internal inputs return to the synchronized pins. Any difference from the last looped levels is flagged under R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address: 0 control, 1 status |
| reg_wr | input | 1 | Write strobe (control register only) |
| reg_rd | input | 1 | Read strobe; a status read clears the deltas |
| reg_wdata | input | 6 | Write data for the control register |
| reg_rdata | output | 8 | Read data for the addressed register (combinational) |
| hs_send_ok_i | input | 1 | Send-ok input from modem |
| hs_peer_rdy_i | input | 1 | Peer-ready input from modem |
| hs_carrier_i | input | 1 | Carrier-detect input from modem |
| hs_ring_i | input | 1 | Ring input from modem |
| hs_term_rdy_o | output | 1 | Terminal-ready output to modem |
| hs_request_o | output | 1 | Request output to modem |
| modem_irq_o | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that the read and write strobes are never both high in the same cycle, and that a strobe is held for exactly one clock. They also assume that the pins change at most once per edge, so that one transition produces one flag. The bench drives every strobe and pin a nanosecond after a rising edge through tasks that each raise one strobe for a single cycle. It moves the pins only between register accesses, except in the one deliberate case where a carrier edge lands on the clearing edge of a status read.

// File: rtl/mhs_pkg.sv
`timescale 1ns/1ps
package mhs_pkg;
    localparam int unsigned N_HS_IN      = 4;
    localparam int unsigned IDX_SEND_OK  = 0;
    localparam int unsigned IDX_PEER_RDY = 1;
    localparam int unsigned IDX_CARRIER  = 2;
    localparam int unsigned IDX_RING     = 3;

    localparam int unsigned CB_TERM_RDY   = 0;
    localparam int unsigned CB_REQUEST    = 1;
    localparam int unsigned CB_LOOP_RING  = 2;
    localparam int unsigned CB_LOOP_CARR  = 3;
    localparam int unsigned CB_LOOP       = 4;
    localparam int unsigned CB_IRQ_EN     = 5;
    localparam int unsigned CTRL_W        = 6;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LOOP   = 1'b1
    } mode_e;
endpackage

// File: rtl/mhs_sync.sv
`timescale 1ns/1ps
module mhs_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mhs_delta.sv
`timescale 1ns/1ps
module mhs_delta #(
    parameter int unsigned WIDTH    = 4,
    parameter int unsigned RING_IDX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] flags_o
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] flag_q;
    logic [WIDTH-1:0] edge_hit;

    for (genvar i = 0; i < int'(WIDTH); i++) begin : g_bit
        if (i == int'(RING_IDX)) begin : g_trail
            assign edge_hit[i] = prev_q[i] & ~level_i[i];

            a_r4_ring_rise_ignored: assert property (@(posedge clk) disable iff (!rst_n)
                (!prev_q[i] && level_i[i] && !flag_q[i]) |=> !flag_q[i]);
            a_r4_ring_fall_flags: assert property (@(posedge clk) disable iff (!rst_n)
                (prev_q[i] && !level_i[i]) |=> flag_q[i]);
            a_r5_ring_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i && !(prev_q[i] && !level_i[i])) |=> !flag_q[i]);
        end else begin : g_any
            assign edge_hit[i] = prev_q[i] ^ level_i[i];

            a_r3_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
                (prev_q[i] != level_i[i]) |=> flag_q[i]);
            a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i && prev_q[i] == level_i[i]) |=> !flag_q[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            flag_q <= '0;
        end else begin
            prev_q <= level_i;
            flag_q <= (flag_q & ~{WIDTH{clr_i}}) | edge_hit;
        end
    end

    assign flags_o = flag_q;
endmodule

// File: rtl/mhs_regs.sv
`timescale 1ns/1ps
module mhs_regs
    import mhs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output mode_e             mode_o,
    output logic              term_rdy_o,
    output logic              request_o
);
    logic [CTRL_W-1:0] ctrl_q;
    mode_e             state_q;
    mode_e             state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else if (wr_en_i) ctrl_q <= wdata_i;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL: if (wr_en_i && wdata_i[CB_LOOP])  state_d = MODE_LOOP;
            MODE_LOOP:   if (wr_en_i && !wdata_i[CB_LOOP]) state_d = MODE_NORMAL;
            default:     state_d = MODE_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        term_rdy_o = 1'b0;
        request_o  = 1'b0;
        unique case (state_q)
            MODE_NORMAL: begin
                term_rdy_o = ctrl_q[CB_TERM_RDY];
                request_o  = ctrl_q[CB_REQUEST];
            end
            MODE_LOOP: begin
                term_rdy_o = 1'b0;
                request_o  = 1'b0;
            end
            default: ;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign mode_o = state_q;

    a_r7_mode_matches_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_LOOP) == ctrl_q[CB_LOOP]);
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ctrl_q == $past(wdata_i));
endmodule

// File: rtl/modem_hs_ctrl.sv
`timescale 1ns/1ps
module modem_hs_ctrl
    import mhs_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              hs_send_ok_i,
    input  logic              hs_peer_rdy_i,
    input  logic              hs_carrier_i,
    input  logic              hs_ring_i,
    output logic              hs_term_rdy_o,
    output logic              hs_request_o,
    output logic              modem_irq_o
);
    localparam int unsigned STAT_W = 2 * N_HS_IN;

    logic [N_HS_IN-1:0] pin_raw;
    logic [N_HS_IN-1:0] pin_sync;
    logic [N_HS_IN-1:0] loop_lvl;
    logic [N_HS_IN-1:0] level;
    logic [N_HS_IN-1:0] flags;
    logic [CTRL_W-1:0]  ctrl;
    mode_e              mode;
    logic               wr_ctrl;
    logic               rd_stat;

    assign pin_raw[IDX_SEND_OK]  = hs_send_ok_i;
    assign pin_raw[IDX_PEER_RDY] = hs_peer_rdy_i;
    assign pin_raw[IDX_CARRIER]  = hs_carrier_i;
    assign pin_raw[IDX_RING]     = hs_ring_i;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign rd_stat = reg_rd && (reg_addr == ADDR_STAT);

    mhs_sync #(.WIDTH(N_HS_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_raw),
        .q_o   (pin_sync)
    );

    mhs_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_ctrl),
        .wdata_i    (reg_wdata),
        .ctrl_o     (ctrl),
        .mode_o     (mode),
        .term_rdy_o (hs_term_rdy_o),
        .request_o  (hs_request_o)
    );

    assign loop_lvl[IDX_SEND_OK]  = ctrl[CB_REQUEST];
    assign loop_lvl[IDX_PEER_RDY] = ctrl[CB_TERM_RDY];
    assign loop_lvl[IDX_CARRIER]  = ctrl[CB_LOOP_CARR];
    assign loop_lvl[IDX_RING]     = ctrl[CB_LOOP_RING];

    assign level = (mode == MODE_LOOP) ? loop_lvl : pin_sync;

    mhs_delta #(.WIDTH(N_HS_IN), .RING_IDX(IDX_RING)) u_delta (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level),
        .clr_i   (rd_stat),
        .flags_o (flags)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
            ADDR_STAT: reg_rdata = {{(DATA_W-STAT_W){1'b0}}, level, flags};
            default:   reg_rdata = '0;
        endcase
    end

    assign modem_irq_o = ctrl[CB_IRQ_EN] & (|flags);

    a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[CB_IRQ_EN] |-> !modem_irq_o);
    a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        modem_irq_o |-> (flags != '0));
    a_r8_loop_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LOOP) |-> (!hs_term_rdy_o && !hs_request_o));
    a_r2_outputs_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL) |-> (hs_term_rdy_o == ctrl[CB_TERM_RDY] &&
                                   hs_request_o  == ctrl[CB_REQUEST]));
endmodule

// File: tb/tb_modem_hs_ctrl.sv
`timescale 1ns/1ps
module tb_modem_hs_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [5:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       send_ok = 1'b0, peer_rdy = 1'b0, carrier = 1'b0, ring = 1'b0;
    logic       term_rdy, request, irq;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    modem_hs_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hs_send_ok_i(send_ok), .hs_peer_rdy_i(peer_rdy),
        .hs_carrier_i(carrier), .hs_ring_i(ring),
        .hs_term_rdy_o(term_rdy), .hs_request_o(request), .modem_irq_o(irq)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares read data while the read strobe is high
    always @(negedge clk) begin
        if (reg_rd && exp_q.size() > 0) begin
            chk(req_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
    end

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_ctrl(logic [5:0] v);
        @(posedge clk); #1;
        reg_addr = 2'd0; reg_wr = 1'b1; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string req);
        @(posedge clk); #1;
        reg_addr = a; reg_rd = 1'b1;
        exp_q.push_back(exp); req_q.push_back(req);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        settle(4);
        rst_n = 1'b1;
        settle(1);
        // R1 reset state
        chk("R1", {5'd0, term_rdy, request, irq}, 8'h00);
        rd(2'd0, 8'h00, "R1");
        rd(2'd1, 8'h00, "R1");

        // R2 control write, readback, outputs
        wr_ctrl(6'h23);
        chk("R2", {6'd0, term_rdy, request}, 8'h03);
        rd(2'd0, 8'h23, "R2");

        // R3 send-ok change, R6 irq, R5 clear on read
        send_ok = 1'b1; settle(3);
        chk("R6", {7'd0, irq}, 8'h01);
        rd(2'd1, 8'h11, "R3");
        rd(2'd1, 8'h10, "R5");
        chk("R6", {7'd0, irq}, 8'h00);
        send_ok = 1'b0; settle(3);
        rd(2'd1, 8'h01, "R3");

        // R4 ring: rise ignored, fall flagged
        ring = 1'b1; settle(3);
        rd(2'd1, 8'h80, "R4");
        chk("R4", {7'd0, irq}, 8'h00);
        ring = 1'b0; settle(3);
        rd(2'd1, 8'h08, "R4");

        // R6 enable gating
        wr_ctrl(6'h03);
        peer_rdy = 1'b1; settle(3);
        chk("R6", {7'd0, irq}, 8'h00);
        wr_ctrl(6'h23);
        chk("R6", {7'd0, irq}, 8'h01);
        rd(2'd1, 8'h22, "R3");
        chk("R6", {7'd0, irq}, 8'h00);

        // R5 change detected on the clearing edge survives
        carrier = 1'b1; settle(1);
        rd(2'd1, 8'h60, "R5");
        rd(2'd1, 8'h64, "R5");
        peer_rdy = 1'b0; carrier = 1'b0; settle(3);
        rd(2'd1, 8'h06, "R3");

        // R7 loopback mapping, R8 outputs parked
        wr_ctrl(6'h35);
        chk("R8", {6'd0, term_rdy, request}, 8'h00);
        rd(2'd1, 8'hA2, "R7");
        rd(2'd0, 8'h35, "R7");
        send_ok = 1'b1; peer_rdy = 1'b1; carrier = 1'b1; ring = 1'b1;
        settle(3);
        rd(2'd1, 8'hA0, "R8");
        chk("R8", {7'd0, irq}, 8'h00);
        wr_ctrl(6'h31);
        rd(2'd1, 8'h28, "R7");

        // R9 leave loopback
        wr_ctrl(6'h23);
        chk("R9", {6'd0, term_rdy, request}, 8'h03);
        rd(2'd1, 8'hF5, "R9");
        chk("R9", {7'd0, irq}, 8'h00);

        settle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule